// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block is a clocked master for a byte-wide asynchronous static RAM with a 20-bit address. A host issues one transfer at a time over a request/acknowledge port that carries an address, a byte of write data and a direction flag. The controller turns each transfer into a strobe sequence on the memory pins: active-low chip select, output enable and write enable, plus a data output with a separate drive enable for an external tristate pad.

Every transfer first spends one cycle with the new address on the pins and all strobes inactive. A read then lowers chip select and output enable together. It keeps them low until the longest of three waits has passed: the address access time, the chip-select access time and the output-enable access time, all counted in clocks. The byte is captured at the end of that wait. A write lowers chip select and write enable for a set pulse width, with output enable held high and the data bus driven. It then holds both strobes high for a set recovery time before it acknowledges. All timing values are parameters of at least one cycle.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `host_ack` is 0.
- R2: A read (`host_write`=0) holds `mem_we_n`=1 and drives `mem_ce_n`=0 and `mem_oe_n`=0. `host_rdata` then holds the byte the memory returned at the requested address.
- R3: With RD = max(ADDR_ACC_CYC-1, CE_ACC_CYC, OE_ACC_CYC), a read holds CE and OE low for exactly RD cycles. That comes after one address-only cycle. The byte is sampled at the last of those edges, so the address has been stable at least ADDR_ACC_CYC cycles. `host_ack` is high 2+RD cycles after the accepting edge.
- R4: A write holds `mem_we_n` and `mem_ce_n` low together for exactly WPULSE_CYC cycles. Both fall one cycle after the address is presented, and `mem_addr` does not change while `mem_ce_n` is low.
- R5: `mem_oe_n` is 1 in every cycle in which `mem_we_n` is 0.
- R6: `mem_dq_oe` is 1 exactly in the cycles where `mem_we_n` is 0, and `mem_dq_o` then carries the accepted write byte.
- R7: After a write window, `mem_we_n` and `mem_ce_n` stay high for RECOV_CYC cycles before `host_ack`. A write is acknowledged 2+WPULSE_CYC+RECOV_CYC cycles after acceptance, and `mem_we_n` never falls after fewer than RECOV_CYC high cycles.
- R8: `host_ack` is high for a single cycle per transfer.
- R9: Changes on `host_addr`, `host_wdata` and `host_write` after the accepting edge have no effect on the running transfer.
- R10: A request held high in the acknowledge cycle is accepted at the next edge, with the same latency as a request from idle.
- R11: All 20 address bits reach `mem_addr`, so every bit position selects a distinct byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Transfer request, sampled while idle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | DATA_W | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for the data pad |
| mem_dq_i | input | DATA_W | Data from memory |

## Verification
Completion of one transfer and acceptance of the next can fall in the same cycle. The bench provokes this by leaving the request high through the acknowledge cycle, with new operands already on the host port, and chains writes and reads to different addresses this way. It then checks that the chained transfer is acknowledged after exactly the latency of a transfer started from idle. A memory model in the bench judges the strobe timing in every cycle: each chained read must return its own address's byte, and the recovery gap before a chained write must still meet its minimum.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM bus controller.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RD_WAIT,
        ST_WR_PULSE,
        ST_WR_RECOV
    } sram_state_t;

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Largest of three integers, never below one.
    function automatic int imax3_min1(input int a, input int b, input int c);
        return imax(1, imax(a, imax(b, c)));
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
// Loadable down-counter used for every strobe phase.
// Assumes: load has priority; expired is high while the count is zero.
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Load a phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Transfer sequencer: idle, address setup, then a read wait or a write
// pulse followed by recovery. Strobes are registered from the next state.
// Assumes: op_write is the latched direction of the accepted request.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC     = 2,
    parameter int WPULSE_CYC = 2,
    parameter int RECOV_CYC  = 1,
    parameter int CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             op_write,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output sram_state_t      st_next,
    output logic             ack,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WPULSE_CYC - 1);
    localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(RECOV_CYC - 1);

    sram_state_t state;
    logic        wr_done;

    // Next-state, timer load and event decode.
    always_comb begin
        st_next  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        wr_done  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req) begin
                    accept  = 1'b1;
                    st_next = ST_SETUP;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (op_write) begin
                    tmr_val = WP_LOAD;
                    st_next = ST_WR_PULSE;
                end else begin
                    tmr_val = RD_LOAD;
                    st_next = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (tmr_expired) begin
                    capture = 1'b1;
                    st_next = ST_IDLE;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = RC_LOAD;
                    st_next  = ST_WR_RECOV;
                end
            end
            ST_WR_RECOV: begin
                if (tmr_expired) begin
                    wr_done = 1'b1;
                    st_next = ST_IDLE;
                end
            end
            default: st_next = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= st_next;
    end

    // Registered strobes and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n <= 1'b1;
            oe_n <= 1'b1;
            we_n <= 1'b1;
            ack  <= 1'b0;
        end else begin
            ce_n <= !((st_next == ST_RD_WAIT) || (st_next == ST_WR_PULSE));
            oe_n <= !(st_next == ST_RD_WAIT);
            we_n <= !(st_next == ST_WR_PULSE);
            ack  <= capture || wr_done;
        end
    end

endmodule

// File: rtl/sram_host_regs.sv
// Host-side holding registers: latches the operands on acceptance,
// captures read data, and registers the data pad drive enable.
// Assumes: accept and capture never coincide.
module sram_host_regs
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  sram_state_t       st_next,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              op_write,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              dq_oe
);

    // Operand latch, loaded only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_write <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            op_write <= host_write;
            addr_q   <= host_addr;
            wdata_q  <= host_wdata;
        end
    end

    // Read data capture at the end of the access wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (capture)
            rdata_q <= mem_dq_i;
    end

    // Data pad drive enable, on only for the write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dq_oe <= 1'b0;
        else
            dq_oe <= (st_next == ST_WR_PULSE);
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
// Top of the asynchronous SRAM bus controller. Joins the sequencer, the
// phase timer and the host registers. Assumes the host holds host_req
// until host_ack; all cycle counts are at least one.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int DATA_W       = 8,
    parameter int ADDR_ACC_CYC = 3,
    parameter int CE_ACC_CYC   = 2,
    parameter int OE_ACC_CYC   = 2,
    parameter int WPULSE_CYC   = 2,
    parameter int RECOV_CYC    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int RD_CYC  = imax3_min1(ADDR_ACC_CYC - 1, CE_ACC_CYC, OE_ACC_CYC);
    localparam int WP_CYC  = imax(1, WPULSE_CYC);
    localparam int RC_CYC  = imax(1, RECOV_CYC);
    localparam int MAX_CYC = imax(RD_CYC, imax(WP_CYC, RC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;
    logic             op_write;
    sram_state_t      st_next;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_seq_fsm #(
        .RD_CYC     (RD_CYC),
        .WPULSE_CYC (WP_CYC),
        .RECOV_CYC  (RC_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (host_req),
        .op_write    (op_write),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .capture     (capture),
        .st_next     (st_next),
        .ack         (host_ack),
        .ce_n        (mem_ce_n),
        .oe_n        (mem_oe_n),
        .we_n        (mem_we_n)
    );

    sram_host_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .st_next    (st_next),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .mem_dq_i   (mem_dq_i),
        .op_write   (op_write),
        .addr_q     (mem_addr),
        .wdata_q    (mem_dq_o),
        .rdata_q    (host_rdata),
        .dq_oe      (mem_dq_oe)
    );

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
// Protocol checker for the SRAM bus controller, bound to every instance.
// Assumes the same cycle-count parameters as the controller it watches.
module sram_bus_ctrl_chk #(
    parameter int ADDR_W     = 20,
    parameter int WPULSE_CYC = 2,
    parameter int RECOV_CYC  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    int hi_cnt;
    int lo_cnt;

    // Count consecutive cycles with write enable high or low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= RECOV_CYC;
            lo_cnt <= 0;
        end else begin
            hi_cnt <= mem_we_n  ? ((hi_cnt < RECOV_CYC + 4) ? hi_cnt + 1 : hi_cnt) : 0;
            lo_cnt <= !mem_we_n ? lo_cnt + 1 : 0;
        end
    end

    // R5: output enable stays high during the write window.
    assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R4: write enable is only low together with chip select.
    assert_we_needs_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R4: address is frozen while chip select is low.
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R4: the write pulse lasts exactly the configured width.
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_cnt == WPULSE_CYC));

    // R6: the data pad is driven only inside the write window.
    assert_drive_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    // R7: write enable falls only after the recovery time.
    assert_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (hi_cnt >= RECOV_CYC));

    // R8: acknowledge is a single-cycle pulse.
    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .WPULSE_CYC (WP_CYC),
    .RECOV_CYC  (RC_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ack  (host_ack),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_bus_ctrl.sv
// Bench: sweeps writes and reads over every address bit with a timing-aware
// memory model, then chains transfers back to back.
module tb_sram_bus_ctrl;

    localparam int AW    = 20;
    localparam int DW    = 8;
    localparam int T_AD  = 4;
    localparam int T_CE  = 2;
    localparam int T_OE  = 1;
    localparam int T_WP  = 3;
    localparam int T_RC  = 2;
    localparam int RD    = (T_AD - 1 > T_CE) ? ((T_AD - 1 > T_OE) ? T_AD - 1 : T_OE)
                                             : ((T_CE > T_OE) ? T_CE : T_OE);
    localparam int RLAT  = 2 + RD;
    localparam int WLAT  = 2 + T_WP + T_RC;
    localparam logic [AW-1:0] GARB = 20'h00ABC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ack;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i = 8'hEE;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sram_bus_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .ADDR_ACC_CYC(T_AD), .CE_ACC_CYC(T_CE),
        .OE_ACC_CYC(T_OE), .WPULSE_CYC(T_WP), .RECOV_CYC(T_RC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural memory: judges strobe timing at every falling clock edge.
    logic [DW-1:0] mem_model [logic [AW-1:0]];
    int ce_c = 0, oe_c = 0, ad_c = 0, lo_c = 0, hi_c = 100;
    logic          prev_win = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [AW-1:0] win_addr = '0;
    logic [DW-1:0] win_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_win && !(!mem_ce_n && !mem_we_n)) begin
                mem_model[win_addr] = win_data;
                chk(lo_c == T_WP, "R4 write window length", lo_c, T_WP);
                chk(!mem_dq_oe, "R6 drive released with window", mem_dq_oe, 0);
                lo_c = 0;
            end
            if (!mem_ce_n && !mem_we_n) begin
                if (!prev_win)
                    chk(hi_c >= T_RC, "R7 recovery before write", hi_c, T_RC);
                if (prev_win && mem_addr != win_addr)
                    chk(0, "R4 address moved in window", mem_addr, win_addr);
                if (!mem_oe_n)
                    chk(0, "R5 OE low during write", 0, 1);
                if (!mem_dq_oe)
                    chk(0, "R6 data not driven in window", 0, 1);
                lo_c++;
                hi_c = 0;
                win_addr = mem_addr;
                win_data = mem_dq_o;
                prev_win = 1'b1;
            end else begin
                prev_win = 1'b0;
                if (mem_we_n && hi_c < 100) hi_c++;
                if (mem_dq_oe)
                    chk(0, "R6 data driven outside window", 1, 0);
            end
            ce_c = !mem_ce_n ? ce_c + 1 : 0;
            oe_c = !mem_oe_n ? oe_c + 1 : 0;
            ad_c = (mem_addr == prev_addr) ? ((ad_c < 100) ? ad_c + 1 : ad_c) : 1;
            prev_addr = mem_addr;
            if (!mem_ce_n && !mem_oe_n && mem_we_n &&
                ce_c >= T_CE && oe_c >= T_OE && ad_c >= T_AD)
                mem_dq_i <= mem_model.exists(mem_addr) ? mem_model[mem_addr] : 8'h00;
            else
                mem_dq_i <= 8'hEE;
        end
    end

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int pass);
        logic [DW-1:0] v;
        v = a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A ^ DW'(pass * 8'h33);
        return v;
    endfunction

    function automatic logic [AW-1:0] sweep_addr(input int i);
        if (i < AW) return AW'(1) << i;
        if (i == AW) return '0;
        return '1;
    endfunction

    // One transfer; scrambles the host operands after acceptance.
    task automatic op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit keep, output int n);
        host_req   = 1'b1;
        host_write = wr;
        host_addr  = a;
        host_wdata = d;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                host_addr  = GARB;
                host_wdata = ~d;
                host_write = ~wr;
            end
            if (host_ack || n > 60) break;
        end
        if (!keep) host_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        logic [AW-1:0] a;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_dq_oe && !host_ack, "R1 drive and ack low in reset",
            {mem_dq_oe, host_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !host_ack, "R1 idle after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, host_ack}, 4'b1110);

        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < AW + 2; i++) begin
                a = sweep_addr(i);
                op(1'b1, a, pat(a, pass), 1'b0, n);
                chk(n == WLAT, "R7 write ack latency", n, WLAT);
                @(negedge clk);
                chk(!host_ack, "R8 ack single cycle after write", host_ack, 0);
            end
            for (int i = 0; i < AW + 2; i++) begin
                a = sweep_addr(i);
                op(1'b0, a, 8'h00, 1'b0, n);
                chk(n == RLAT, "R3 read ack latency", n, RLAT);
                chk(host_rdata == pat(a, pass), "R2 R11 read data per address bit",
                    host_rdata, pat(a, pass));
                @(negedge clk);
                chk(!host_ack, "R8 ack single cycle after read", host_ack, 0);
                chk(host_rdata == pat(a, pass), "R2 read data held", host_rdata, pat(a, pass));
            end
        end

        // R10: chained transfers with the request held through each ack.
        op(1'b1, 20'h12345, 8'hC3, 1'b1, n);
        chk(n == WLAT, "R10 first chained write latency", n, WLAT);
        op(1'b1, 20'h54321, 8'h3C, 1'b1, n);
        chk(n == WLAT, "R10 second chained write latency", n, WLAT);
        op(1'b0, 20'h12345, 8'h00, 1'b1, n);
        chk(n == RLAT, "R10 chained read latency", n, RLAT);
        chk(host_rdata == 8'hC3, "R10 chained read data A", host_rdata, 8'hC3);
        op(1'b0, 20'h54321, 8'h00, 1'b1, n);
        chk(n == RLAT, "R10 read after read latency", n, RLAT);
        chk(host_rdata == 8'h3C, "R10 chained read data B", host_rdata, 8'h3C);
        op(1'b1, 20'h0F0F0, 8'hA5, 1'b0, n);
        chk(n == WLAT, "R10 write after read latency", n, WLAT);
        op(1'b0, 20'h0F0F0, 8'h00, 1'b0, n);
        chk(host_rdata == 8'hA5, "R10 write after read data", host_rdata, 8'hA5);

        // R9: scrambled operands after acceptance never reached the memory.
        op(1'b0, GARB, 8'h00, 1'b0, n);
        chk(host_rdata == 8'h00, "R9 scrambled address never written", host_rdata, 8'h00);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule